// File: doc/BRIEF.md
# Bank-Switching Memory Map Decoder

This block decodes every CPU access in a 64 KB address space into exactly one device select. Three windows of the map can switch between RAM and an overlay device. One is a 8 KB window at 0xA000 for the interpreter ROM. One is a 4 KB window at 0xD000 for the I/O area or the character ROM. One is a 8 KB window at 0xE000 for the system ROM. The rest of the map is always RAM.

Three active-low control bits, taken from the CPU's on-chip port, set the overlays. Bits [1:0] form a two-bit overlay level, and each step up the level adds one device. Level 0 maps nothing. Level 1 adds I/O. Level 2 adds the system ROM. Level 3 adds the interpreter ROM. Bit 2 is a substitution flag. While it is low, the character ROM takes the place of I/O, but only at levels where I/O would be present.

Writes never reach a ROM. They fall through to the RAM underneath. The select is registered and is valid one clock after the address, write strobe and control bits are presented.

Top module: `bank_map_decoder`

## Requirements
- R1: Addresses 0x0000–0x9FFF and 0xC000–0xCFFF always select RAM, whatever the control bits or the write strobe.
- R2: For a read in 0xA000–0xBFFF, the interpreter ROM (sel bit 4) is selected only when ctl_n[1:0] = 11. Otherwise RAM is selected.
- R3: For a read in 0xE000–0xFFFF, the system ROM (sel bit 3) is selected when ctl_n[1] = 1, which covers levels 10 and 11. Otherwise RAM is selected.
- R4: At levels 01, 10 and 11 with ctl_n[2] = 1, an access in 0xD000–0xDFFF selects I/O (sel bit 1), for both reads and writes.
- R5: At levels 01, 10 and 11 with ctl_n[2] = 0, a read in 0xD000–0xDFFF selects the character ROM (sel bit 2), and a write there selects RAM.
- R6: At level 00, 0xD000–0xDFFF selects RAM, whatever the value of ctl_n[2].
- R7: A write (wr = 1) never selects any ROM (sel bits 2, 3 and 4). A write to a ROM-mapped address selects RAM (sel bit 0).
- R8: After reset, exactly one bit of sel is set in every cycle.
- R9: sel reflects the addr, wr and ctl_n values sampled at the previous rising clock edge.
- R10: While rst_n is low at a clock edge, sel becomes RAM only (5'b00001).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | CPU address |
| wr | input | 1 | 1 = write access, 0 = read access |
| ctl_n | input | 3 | Active-low control bits: [1:0] overlay level, [2] character ROM substitution |
| sel | output | 5 | One-hot select: [0] RAM, [1] I/O, [2] char ROM, [3] system ROM, [4] interpreter ROM |

## Verification
The bench tries all eight control-bit values with reads and with writes. Each combination is applied to the first and last address of every window. This separates an off-by-one window edge (0x9FFF/0xA000, 0xCFFF/0xD000, 0xDFFF/0xE000) from a wrong level threshold. The write passes show whether a ROM select leaks through on stores. The two settings of the substitution flag at level 0 show whether the character ROM wrongly appears when I/O is absent. Back-to-back vectors with different windows check that each result lines up with the input of the previous cycle.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  localparam int SEL_W = 5;
  localparam int S_RAM = 0;
  localparam int S_IO  = 1;
  localparam int S_CHR = 2;
  localparam int S_KRN = 3;
  localparam int S_BAS = 4;

  typedef enum logic [1:0] {Z_FIXED, Z_BASIC, Z_IOCHR, Z_KERNAL} zone_e;

  // Window of an address from its top nibble.
  function automatic zone_e zone_of(input logic [3:0] nib);
    case (nib)
      4'hA, 4'hB: return Z_BASIC;
      4'hD:       return Z_IOCHR;
      4'hE, 4'hF: return Z_KERNAL;
      default:    return Z_FIXED;
    endcase
  endfunction

  function automatic logic [SEL_W-1:0] one_sel(input int idx);
    return SEL_W'(1) << idx;
  endfunction
endpackage

// File: rtl/bm_zone_decode.sv
module bm_zone_decode
  import bankmap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output zone_e             zone
);
  localparam int NIB_LSB = ADDR_W - 4;

  always_comb zone = zone_of(addr[ADDR_W-1:NIB_LSB]);
endmodule

// File: rtl/bm_overlay.sv
module bm_overlay
  import bankmap_pkg::*;
(
  input  zone_e            zone,
  input  logic [1:0]       level,
  input  logic             chr_n,
  input  logic             wr,
  output logic [SEL_W-1:0] sel
);
  logic io_mapped;
  logic krn_mapped;
  logic bas_mapped;

  always_comb begin
    io_mapped  = (level != 2'b00);
    krn_mapped = level[1];
    bas_mapped = (level == 2'b11);
  end

  always_comb begin
    sel = one_sel(S_RAM);
    unique case (zone)
      Z_BASIC:  if (bas_mapped && !wr) sel = one_sel(S_BAS);
      Z_KERNAL: if (krn_mapped && !wr) sel = one_sel(S_KRN);
      Z_IOCHR: begin
        if (io_mapped) begin
          if (chr_n)    sel = one_sel(S_IO);
          else if (!wr) sel = one_sel(S_CHR);
        end
      end
      default: sel = one_sel(S_RAM);
    endcase
  end
endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
  import bankmap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        wr,
  input  logic [2:0]  ctl_n,
  output logic [4:0]  sel
);
  localparam int ADDR_W = 16;

  zone_e            zone;
  logic [SEL_W-1:0] sel_d;
  logic [SEL_W-1:0] sel_q;

  bm_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
    .addr (addr),
    .zone (zone)
  );

  bm_overlay u_ovl (
    .zone  (zone),
    .level (ctl_n[1:0]),
    .chr_n (ctl_n[2]),
    .wr    (wr),
    .sel   (sel_d)
  );

  // R9 / R10: one register stage, reset to RAM
  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= one_sel(S_RAM);
    else        sel_q <= sel_d;
  end

  assign sel = sel_q;

  a_r8_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_q) == 1);

  a_r1_fixed_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (zone == Z_FIXED) |=> (sel_q == one_sel(S_RAM)));

  a_r7_write_no_rom: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (sel_q[S_BAS] == 1'b0 && sel_q[S_KRN] == 1'b0 && sel_q[S_CHR] == 1'b0));

  a_r6_level0_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_n[1:0] == 2'b00) |=> (sel_q == one_sel(S_RAM)));

  a_r5_char_read: assert property (@(posedge clk) disable iff (!rst_n)
    (zone == Z_IOCHR && ctl_n[1:0] != 2'b00 && !ctl_n[2] && !wr) |=> sel_q[S_CHR]);

  a_r4_io_mapped: assert property (@(posedge clk) disable iff (!rst_n)
    (zone == Z_IOCHR && ctl_n[1:0] != 2'b00 && ctl_n[2]) |=> sel_q[S_IO]);
endmodule

// File: tb/tb_bank_map_decoder.sv
module tb_bank_map_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0;
  logic        wr = 1'b0;
  logic [2:0]  ctl_n = 3'b111;
  logic [4:0]  sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  bank_map_decoder dut (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr    (wr),
    .ctl_n (ctl_n),
    .sel   (sel)
  );

  // Expected select from the requirements, written as range tests.
  function automatic item_t model(input logic [15:0] a, input logic w, input logic [2:0] c);
    item_t it;
    it.exp = 5'b00001;
    if (a < 16'hA000 || (a >= 16'hC000 && a < 16'hD000)) begin
      it.tag = "R1";
    end else if (a < 16'hC000) begin
      it.tag = w ? "R7" : "R2";
      if (!w && c[1:0] == 2'd3) it.exp = 5'b10000;
    end else if (a >= 16'hE000) begin
      it.tag = w ? "R7" : "R3";
      if (!w && c[1:0] >= 2'd2) it.exp = 5'b01000;
    end else if (c[1:0] == 2'd0) begin
      it.tag = "R6";
    end else if (c[2]) begin
      it.tag = "R4";
      it.exp = 5'b00010;
    end else begin
      it.tag = "R5";
      if (!w) it.exp = 5'b00100;
    end
    return it;
  endfunction

  task automatic drive(input logic [15:0] a, input logic w, input logic [2:0] c);
    @(negedge clk);
    addr = a; wr = w; ctl_n = c;
    sb.push_back(model(a, w, c));
  endtask

  // Monitor: the result for each vector appears after the next rising edge (R9).
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if ($countones(sel) != 1) begin
        n_bad++;
        $display("FAIL R8 not one-hot: actual %b expected one bit set", sel);
      end
      if (sel !== it.exp) begin
        n_bad++;
        $display("FAIL %s/R9 addr=%h wr=%b ctl_n=%b: actual %b expected %b",
                 it.tag, addr, wr, ctl_n, sel, it.exp);
      end
    end
  end

  initial begin
    logic [15:0] pts [12];
    pts = '{16'h0000, 16'h9FFF, 16'hA000, 16'hBFFF, 16'hC000, 16'hCFFF,
            16'hD000, 16'hD7A5, 16'hDFFF, 16'hE000, 16'hFFFF, 16'h4321};
    // R10: reset state
    addr = 16'hA000; wr = 1'b0; ctl_n = 3'b111;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (sel !== 5'b00001) begin
      n_bad++;
      $display("FAIL R10 reset select: actual %b expected %b", sel, 5'b00001);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < 12; p++)
          drive(pts[p], w[0], c[2:0]);
    repeat (3) @(negedge clk);
    // R10 again: reset mid-run after a ROM select
    drive(16'hE123, 1'b0, 3'b011);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    n_chk++;
    if (sel !== 5'b00001) begin
      n_bad++;
      $display("FAIL R10 reset mid-run: actual %b expected %b", sel, 5'b00001);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: actual hung expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule